// File: doc/BRIEF.md
# Dyadic and Dither Duty Modulator

This block sits beside a PWM core and decides, once per switching period, whether that period's duty should be one count longer than the base duty. A modulation length m (0 to 7) defines a window of 2^m periods. Across that window the m low bits of the control word, or a constant word held in configuration, are spread as +1 requests, so the average duty gains up to m bits of resolution with no change to the core's own width.

Three small configuration registers are written through a multiplexed bus made of a write strobe, a 3-bit address and 8 data bits. They select the modulation mode, the modulation length, the source of the modulation word and the PWM resolution code that the core uses. There are five modes. Normal issues no +1 requests. Dyadic mode gives a binary-weighted spread of +1s. Three dither variants compare the low word against the period index, and they differ in when the low word and the base duty are captured inside a window.

The host pulses `period_start_i` at the first cycle of each switching period. The block registers the decision for that period and holds it until the next pulse. It also registers the base duty that the core should apply during the period.

Top module: `duty_mod`

## Requirements
- R1: After reset `bump_o` is 0, `base_duty_o` is 0 and `res_code_o` is 3. The reset configuration is mode normal, modulation length 0, constant flag clear and constant word 0.
- R2: A write takes place on a clock edge with `cfg_we_i` high. Address 0 loads the control register: data bits [2:0] are the length m, bits [5:3] the mode (0 normal, 1 dyadic, 2 dither v1, 3 dither v2, 4 dither v3) and bit 6 the constant flag. Address 1 loads `res_code_o` from data bits [2:0], visible the cycle after the edge. Address 2 loads the constant word from data bits [6:0]. Addresses 3 to 7 change nothing.
- R3: In normal mode, or whenever m is 0, `bump_o` stays 0.
- R4: The period index k starts at 0, steps once per `period_start_i` pulse and wraps from 2^m−1 to 0. `bump_o` and `base_duty_o` take the value for index k in the cycle after the pulse and hold it until the next pulse.
- R5: In dyadic mode, with w the modulation word masked to m bits, `bump_o` is w[h], where h is the index of the highest set bit of k. At k = 0 it is 0. Over one window the number of +1s equals w.
- R6: In dither v1, `bump_o` is (w ≥ k), with w taken live at every period.
- R7: In dither v2, w is captured at the period with k = 0 and that captured value is used for the rest of the window.
- R8: In dither v3, w is captured as in v2, and `base_duty_o` is captured from `base_duty_i` at k = 0 and held for the window. In every other mode `base_duty_o` takes `base_duty_i` at every period start.
- R9: While the constant flag is set, the constant word takes the place of `ctrl_lsb_i` as the modulation word.
- R10: A write to address 0 clears `bump_o` in the following cycle and makes the next period index 0.
- R11: Mode codes 5 to 7 behave as normal: `bump_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | One-cycle pulse at the start of each switching period |
| ctrl_lsb_i | input | 7 | Low bits of the control word (modulation word) |
| base_duty_i | input | 9 | Base duty from the control path |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_data_i | input | 8 | Configuration write data |
| bump_o | output | 1 | +1 request for the current period |
| base_duty_o | output | 9 | Base duty to apply in the current period |
| res_code_o | output | 3 | PWM resolution code |

## Verification
The bench builds the block with its default parameters: a 7-bit modulation word, a 9-bit base duty and an 8-bit configuration bus. These values give the full length range of 0 to 7. The bench runs a complete 128-period dyadic window and counts its +1s against the word. Shorter windows of 4, 8 and 16 periods let the v2 and v3 capture points, a mid-window restart and the wrap be seen against the period index within a few hundred cycles.

// File: rtl/duty_mod_pkg.sv
package duty_mod_pkg;
  localparam int LEN_W  = 3;
  localparam int MODE_W = 3;
  localparam int CTL_W  = 1 + MODE_W + LEN_W;

  typedef enum logic [MODE_W-1:0] {
    MD_NORMAL = 3'd0,
    MD_DYADIC = 3'd1,
    MD_DITH1  = 3'd2,
    MD_DITH2  = 3'd3,
    MD_DITH3  = 3'd4
  } mode_e;

  typedef struct packed {
    logic              const_sel;
    logic [MODE_W-1:0] mode;
    logic [LEN_W-1:0]  len;
  } ctl_t;

  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_RES  = 3'd1;
  localparam logic [2:0] A_WORD = 3'd2;
endpackage

// File: rtl/dmod_cfg_regs.sv
module dmod_cfg_regs
  import duty_mod_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int RES_W   = 3,
  parameter int WORD_W  = 7,
  parameter int RES_RST = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output ctl_t              ctl_o,
  output logic [RES_W-1:0]  res_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ctl_wr_o
);
  localparam logic [RES_W-1:0] RES_INIT = RES_W'(RES_RST);

  logic wr_ctl, wr_res, wr_word;
  assign wr_ctl  = we_i && (addr_i == ADDR_W'(A_CTL));
  assign wr_res  = we_i && (addr_i == ADDR_W'(A_RES));
  assign wr_word = we_i && (addr_i == ADDR_W'(A_WORD));
  assign ctl_wr_o = wr_ctl;

  logic unused_data_hi;
  assign unused_data_hi = &{1'b0, data_i[DATA_W-1:CTL_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      res_o  <= RES_INIT;
      word_o <= '0;
    end else begin
      if (wr_ctl)  ctl_o  <= ctl_t'(data_i[CTL_W-1:0]);
      if (wr_res)  res_o  <= data_i[RES_W-1:0];
      if (wr_word) word_o <= data_i[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/dmod_window.sv
module dmod_window
  import duty_mod_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mask_o,
  output logic             first_o
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    if (int'(len_i) >= CNT_W) mask_o = '1;
    else                      mask_o = CNT_W'((ONE << len_i) - ONE);
  end

  assign first_o = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else if (step_i)    cnt_o <= (cnt_o >= mask_o) ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/dmod_decide.sv
module dmod_decide
  import duty_mod_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  mask_i,
  input  logic [CNT_W-1:0]  word_i,
  output logic              bump_o
);
  localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  logic [CNT_W-1:0] w;
  logic [IDX_W-1:0] top_idx;
  logic             any_set;

  assign w = word_i & mask_i;

  // highest set bit of the period index
  always_comb begin
    top_idx = '0;
    any_set = 1'b0;
    for (int i = 0; i < CNT_W; i++) begin
      if (cnt_i[i]) begin
        top_idx = IDX_W'(i);
        any_set = 1'b1;
      end
    end
  end

  always_comb begin
    bump_o = 1'b0;
    if (mask_i != '0) begin
      case (mode_i)
        MD_DYADIC:                     bump_o = any_set && w[top_idx];
        MD_DITH1, MD_DITH2, MD_DITH3:  bump_o = (w >= cnt_i);
        default:                       bump_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/duty_mod.sv
module duty_mod
  import duty_mod_pkg::*;
#(
  parameter int LSB_W   = 7,
  parameter int DUTY_W  = 9,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int RES_W   = 3,
  parameter int RES_RST = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              period_start_i,
  input  logic [LSB_W-1:0]  ctrl_lsb_i,
  input  logic [DUTY_W-1:0] base_duty_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              bump_o,
  output logic [DUTY_W-1:0] base_duty_o,
  output logic [RES_W-1:0]  res_code_o
);
  ctl_t             ctl;
  logic [LSB_W-1:0] const_word;
  logic             ctl_wr;
  logic [LSB_W-1:0] cnt, win_mask;
  logic             win_first;
  logic [LSB_W-1:0] src_word, samp_word, eff_word;
  logic             hold_win, bump_n;

  dmod_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W),
    .WORD_W(LSB_W), .RES_RST(RES_RST)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_data_i),
    .ctl_o   (ctl),
    .res_o   (res_code_o),
    .word_o  (const_word),
    .ctl_wr_o(ctl_wr)
  );

  dmod_window #(.CNT_W(LSB_W)) u_win (
    .clk_i, .rst_ni,
    .step_i   (period_start_i),
    .restart_i(ctl_wr),
    .len_i    (ctl.len),
    .cnt_o    (cnt),
    .mask_o   (win_mask),
    .first_o  (win_first)
  );

  assign src_word = ctl.const_sel ? const_word : ctrl_lsb_i;
  assign hold_win = (ctl.mode == MD_DITH2) || (ctl.mode == MD_DITH3);
  assign eff_word = (hold_win && !win_first) ? samp_word : src_word;

  dmod_decide #(.CNT_W(LSB_W)) u_dec (
    .mode_i(ctl.mode),
    .cnt_i (cnt),
    .mask_i(win_mask),
    .word_i(eff_word),
    .bump_o(bump_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_word   <= '0;
      bump_o      <= 1'b0;
      base_duty_o <= '0;
    end else if (ctl_wr) begin
      bump_o <= 1'b0;
    end else if (period_start_i) begin
      bump_o <= bump_n;
      if (win_first) samp_word <= src_word;
      if (!(ctl.mode == MD_DITH3 && !win_first)) base_duty_o <= base_duty_i;
    end
  end
endmodule

// File: rtl/duty_mod_chk.sv
module duty_mod_chk
  import duty_mod_pkg::*;
#(
  parameter int LSB_W  = 7,
  parameter int DUTY_W = 9,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int RES_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              period_start_i,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [DATA_W-1:0] cfg_data_i,
  input logic              bump_o,
  input logic [DUTY_W-1:0] base_duty_o,
  input logic [RES_W-1:0]  res_code_o,
  input logic [MODE_W-1:0] mode,
  input logic [LEN_W-1:0]  len,
  input logic [LSB_W-1:0]  cnt,
  input logic [LSB_W-1:0]  win_mask
);
  // R3
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_NORMAL || len == '0) |-> !bump_o);

  // R11
  unused_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode > MD_DITH3) |-> !bump_o);

  // R4
  cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt & ~win_mask) == '0);

  // R4
  bump_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(period_start_i) && !$past(cfg_we_i)) |-> $stable(bump_o));

  // R2
  res_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(A_RES)) |=> res_code_o == $past(cfg_data_i[RES_W-1:0]));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(A_CTL)) |=> (!bump_o && cnt == '0));

  // R8
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && mode == MD_DITH3 && cnt != '0) |=> $stable(base_duty_o));
endmodule

bind duty_mod duty_mod_chk #(
  .LSB_W(LSB_W), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)
) u_chk (
  .clk_i, .rst_ni, .period_start_i, .cfg_we_i, .cfg_addr_i, .cfg_data_i,
  .bump_o, .base_duty_o, .res_code_o,
  .mode(ctl.mode), .len(ctl.len), .cnt(cnt), .win_mask(win_mask)
);

// File: tb/sim_duty_mod.sv
`timescale 1ns/1ps
module sim_duty_mod;
  localparam int LSB_W = 7, DUTY_W = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              period_start = 0, cfg_we = 0, bump;
  logic [LSB_W-1:0]  ctrl_lsb = '0;
  logic [DUTY_W-1:0] base_in = '0, base_out;
  logic [2:0]        cfg_addr = '0, res_code;
  logic [7:0]        cfg_data = '0;

  duty_mod u0 (
    .clk_i(clk), .rst_ni(rst_ni), .period_start_i(period_start),
    .ctrl_lsb_i(ctrl_lsb), .base_duty_i(base_in),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .bump_o(bump), .base_duty_o(base_out), .res_code_o(res_code)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state, from the requirements
  int m_mode = 0, m_len = 0, m_word = 0, k = 0, samp = 0, base_exp = 0;
  bit m_const = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(int addr, int data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(addr); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 0;
    if (addr == 0) begin
      m_len = data & 7; m_mode = (data >> 3) & 7; m_const = data[6]; k = 0;
    end else if (addr == 2) begin
      m_word = data & 8'h7F;
    end
  endtask

  function automatic int model_bump();
    int mask = (1 << m_len) - 1;
    int src  = m_const ? m_word : int'(ctrl_lsb);
    int w    = ((m_mode == 3 || m_mode == 4) && k != 0) ? samp : src;
    int hb   = -1;
    w = w & mask;
    for (int i = 0; i < LSB_W; i++) if ((k >> i) & 1) hb = i;
    if (m_len == 0) return 0;
    case (m_mode)
      1: return (hb >= 0) ? ((w >> hb) & 1) : 0;
      2, 3, 4: return (w >= k) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // one switching period, 3 cycles long; returns the observed bump
  task automatic period(string req, output bit got);
    int exp_b = model_bump();
    int mask  = (1 << m_len) - 1;
    if (k == 0) samp = m_const ? m_word : int'(ctrl_lsb);
    if (!(m_mode == 4 && k != 0)) base_exp = int'(base_in);
    k = (k >= mask) ? 0 : k + 1;
    @(negedge clk); period_start = 1;
    @(negedge clk); period_start = 0;
    got = bump;
    check({req, " bump"}, int'(bump), exp_b);
    check({req, " base"}, int'(base_out), base_exp);
    @(negedge clk);
    check("R4 hold", int'(bump), exp_b);
  endtask

  task automatic t_reset();
    check("R1 bump", int'(bump), 0);
    check("R1 base", int'(base_out), 0);
    check("R1 res", int'(res_code), 3);
  endtask

  task automatic t_off();
    bit b;
    ctrl_lsb = 7'h7F;
    cfg_wr(0, 8'h04);                       // normal, m=4
    for (int i = 0; i < 16; i++) period("R3 normal", b);
    cfg_wr(0, 8'h08);                       // dyadic, m=0
    for (int i = 0; i < 4; i++) period("R3 m0", b);
  endtask

  task automatic t_regs();
    bit b;
    cfg_wr(1, 8'hFD);
    check("R2 res", int'(res_code), 5);
    cfg_wr(0, 8'h0B);                       // dyadic m=3
    ctrl_lsb = 7'h07;
    period("R2 setup", b); period("R2 setup", b);
    for (int a = 3; a < 8; a++) cfg_wr(a, 8'h01);
    check("R2 unused addr res", int'(res_code), 5);
    for (int i = 0; i < 6; i++) period("R2 unused addr", b);
    cfg_wr(1, 8'h03);
    check("R2 res restore", int'(res_code), 3);
  endtask

  task automatic t_dyadic();
    bit b;
    int words[4] = '{7'h0B, 7'h0F, 7'h00, 7'h05};
    foreach (words[j]) begin
      int cnt = 0;
      cfg_wr(0, 8'h0C);                     // dyadic, m=4
      ctrl_lsb = 7'(words[j]);
      for (int i = 0; i < 16; i++) begin period("R5", b); cnt += int'(b); end
      check("R5 window count", cnt, words[j] & 15);
    end
    begin
      int cnt = 0;
      cfg_wr(0, 8'h0F);                     // dyadic, m=7
      ctrl_lsb = 7'h55;
      for (int i = 0; i < 128; i++) begin period("R5 m7", b); cnt += int'(b); end
      check("R5 m7 count", cnt, 8'h55);
    end
  endtask

  task automatic t_dith1();
    bit b;
    cfg_wr(0, 8'h13);                       // v1, m=3
    ctrl_lsb = 7'h05;
    for (int i = 0; i < 4; i++) period("R6", b);
    ctrl_lsb = 7'h02;                       // live change mid-window
    for (int i = 0; i < 12; i++) period("R6 live", b);
  endtask

  task automatic t_dith2();
    bit b;
    int cnt = 0;
    cfg_wr(0, 8'h1B);                       // v2, m=3
    ctrl_lsb = 7'h06;
    for (int i = 0; i < 3; i++) begin period("R7", b); cnt += int'(b); end
    ctrl_lsb = 7'h01;
    for (int i = 0; i < 5; i++) begin period("R7 held", b); cnt += int'(b); end
    check("R7 window count", cnt, 7);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin period("R7 next", b); cnt += int'(b); end
    check("R7 next count", cnt, 2);
  endtask

  task automatic t_dith3();
    bit b;
    cfg_wr(0, 8'h22);                       // v3, m=2
    ctrl_lsb = 7'h01; base_in = 9'd100;
    period("R8", b); period("R8", b);
    base_in = 9'd200; ctrl_lsb = 7'h03;
    period("R8 held", b); period("R8 held", b);
    check("R8 base held", int'(base_out), 100);
    period("R8 next", b);
    check("R8 base next", int'(base_out), 200);
    cfg_wr(0, 8'h12);                       // v1, m=2: base tracks
    base_in = 9'd50;  period("R8 track", b);
    base_in = 9'd60;  period("R8 track", b);
    check("R8 track", int'(base_out), 60);
  endtask

  task automatic t_const();
    bit b;
    int cnt = 0;
    cfg_wr(2, 8'h85);                       // word 5
    cfg_wr(0, 8'h4B);                       // const, dyadic, m=3
    ctrl_lsb = 7'h02;
    for (int i = 0; i < 8; i++) begin period("R9", b); cnt += int'(b); end
    check("R9 count", cnt, 5);
    cfg_wr(0, 8'h0B);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin period("R9 off", b); cnt += int'(b); end
    check("R9 off count", cnt, 2);
  endtask

  task automatic t_restart();
    bit b;
    cfg_wr(0, 8'h0B);                       // dyadic, m=3
    ctrl_lsb = 7'h07;
    period("R10 pre", b); period("R10 pre", b); period("R10 pre", b);
    check("R10 pre bump", int'(bump), 1);
    cfg_wr(0, 8'h0B);
    check("R10 cleared", int'(bump), 0);
    period("R10 k0", b);
    period("R10 k1", b);
    check("R10 k1 bump", int'(b), 1);
  endtask

  task automatic t_badmode();
    bit b;
    ctrl_lsb = 7'h7F;
    for (int md = 5; md < 8; md++) begin
      cfg_wr(0, (md << 3) | 3);
      for (int i = 0; i < 8; i++) period("R11", b);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_off();
    t_regs();
    t_dyadic();
    t_dith1();
    t_dith2();
    t_dith3();
    t_const();
    t_restart();
    t_badmode();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule